// File: doc/BRIEF.md
# I2C Double-Buffered Data and Flag Controller

This block is the byte-level data path and status core for an I2C master. It keeps three byte stores: a CPU-facing transmit buffer, a shift register shared with the bit-level engine, and a CPU-facing receive buffer. Bytes move on their own between these stores. A buffered transmit byte goes to the shift register as soon as the shift register is free. A received byte goes to the receive buffer as soon as that buffer has been read.

The bit engine reports start, stop, byte-out, byte-in, arbitration-loss and acknowledge events. The block answers with the byte to shift out, with a load pulse, and with a hold request. The engine uses the hold request to keep SCL low while a finished byte has nowhere to go. Sticky flags record a lost arbitration and a detected stop, and a single interrupt line merges the enabled flags.

Top module: `i2c_dbuf_flags`

## Requirements
- R1: After reset, all flags read 0 (txe, rxf, busy, al, stop_flag, ack_stat, master, tx_mode, hold, shift_load, irq), and shift_data and rx_data read 0x00.
- R2: A start event sets busy and txe. In transmit mode, hold stays high until the first byte is written.
- R3: A CPU write loads the transmit buffer and clears txe in the same edge. If the shift register is waiting for a byte, the buffer moves across on the next edge. One cycle after that move, shift_load is high for one cycle, shift_data shows the byte and txe is 1.
- R4: A byte-out event while txe=0 moves the buffer into the shift register on that edge. After that edge, shift_load is 1, txe is 1 and hold is 0.
- R5: A byte-out event while txe=1 moves nothing, and hold goes to 1. The next CPU write drops hold, and the byte reaches the shift register one edge later.
- R6: A byte-in event while rxf=0 puts rx_byte into rx_data and sets rxf.
- R7: A byte-in event while rxf=1 leaves rx_data unchanged, holds the byte in the shift register and raises hold. A CPU read then moves the held byte into rx_data, keeps rxf at 1 and drops hold. A further read clears rxf.
- R8: An arbitration-loss event clears master and tx_mode and sets al. al stays 1 until a clr_al strobe.
- R9: A stop event clears busy and sets stop_flag. stop_flag stays 1 until a clr_stop strobe.
- R10: At a byte-out event with ack_chk_en=1, ack_stat takes the value of ack_bit. With ack_chk_en=0, ack_stat is unchanged.
- R11: irq is high when any enabled flag is set. irq_en bit 0 enables txe, bit 1 enables rxf, bit 2 enables al and bit 3 enables stop_flag.
- R12: A mode_wr strobe loads master from mode_master and tx_mode from mode_tx, unless an arbitration-loss event arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_wr | input | 1 | CPU write strobe to the data register |
| cpu_rd | input | 1 | CPU read strobe of the data register |
| cpu_wdata | input | 8 | CPU write data |
| mode_wr | input | 1 | Mode write strobe |
| mode_master | input | 1 | Master bit value for mode_wr |
| mode_tx | input | 1 | Transmit bit value for mode_wr |
| clr_al | input | 1 | Write-0 strobe for al |
| clr_stop | input | 1 | Write-0 strobe for stop_flag |
| ack_chk_en | input | 1 | Acknowledge checking enable |
| irq_en | input | 4 | Interrupt enables {stop, al, rxf, txe} |
| ev_start | input | 1 | Start condition detected |
| ev_stop | input | 1 | Stop condition detected |
| ev_tx_done | input | 1 | Byte shifted out |
| ev_rx_done | input | 1 | Byte shifted in |
| ev_arb_lost | input | 1 | Arbitration lost |
| ack_bit | input | 1 | Sampled acknowledge bit |
| rx_byte | input | 8 | Byte assembled by the bit engine |
| master | output | 1 | Master mode |
| tx_mode | output | 1 | Transmit mode |
| busy | output | 1 | Bus busy |
| txe | output | 1 | Transmit buffer empty |
| rxf | output | 1 | Receive buffer full |
| al | output | 1 | Arbitration lost flag |
| stop_flag | output | 1 | Stop detected flag |
| ack_stat | output | 1 | Acknowledge status |
| shift_load | output | 1 | One-cycle pulse: new byte in shift register |
| shift_data | output | 8 | Shift register contents |
| rx_data | output | 8 | Receive buffer contents |
| hold | output | 1 | Request to stretch SCL |
| irq | output | 1 | Merged interrupt request |

## Verification
The hardest case to reach is the double-occupancy one. A second byte arrives while the receive buffer is still full, and it has to wait in the shift register. In transmit, the mirror case is a byte finishing with nothing buffered. The vector table walks a transmit sequence and a receive sequence back to back, with byte-out and byte-in events issued before the CPU has serviced the buffer. It then checks that hold rises and that the parked byte comes out only after the CPU write or read.

// File: rtl/i2c_dbuf_flags.sv
module i2c_dbuf_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_wr,
  input  logic         cpu_rd,
  input  logic [W-1:0] cpu_wdata,
  input  logic         mode_wr,
  input  logic         mode_master,
  input  logic         mode_tx,
  input  logic         clr_al,
  input  logic         clr_stop,
  input  logic         ack_chk_en,
  input  logic [3:0]   irq_en,
  input  logic         ev_start,
  input  logic         ev_stop,
  input  logic         ev_tx_done,
  input  logic         ev_rx_done,
  input  logic         ev_arb_lost,
  input  logic         ack_bit,
  input  logic [W-1:0] rx_byte,
  output logic         master,
  output logic         tx_mode,
  output logic         busy,
  output logic         txe,
  output logic         rxf,
  output logic         al,
  output logic         stop_flag,
  output logic         ack_stat,
  output logic         shift_load,
  output logic [W-1:0] shift_data,
  output logic [W-1:0] rx_data,
  output logic         hold,
  output logic         irq
);

  logic [W-1:0] tbuf;
  logic         sh_idle;
  logic         sh_full;
  logic         move_tx;
  logic         rd_take;

  assign move_tx = tx_mode & ~txe & (sh_idle | ev_tx_done);
  assign rd_take = cpu_rd & rxf;
  assign hold    = busy & ((tx_mode & sh_idle & txe) | (~tx_mode & sh_full));
  assign irq     = |(irq_en & {stop_flag, al, rxf, txe});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbuf <= '0; shift_data <= '0; rx_data <= '0;
      txe <= 1'b0; rxf <= 1'b0; sh_idle <= 1'b0; sh_full <= 1'b0;
      shift_load <= 1'b0; busy <= 1'b0; al <= 1'b0; stop_flag <= 1'b0;
      ack_stat <= 1'b0; master <= 1'b0; tx_mode <= 1'b0;
    end else begin
      shift_load <= move_tx;
      if (cpu_wr) tbuf <= cpu_wdata;

      if (ev_start)    txe <= 1'b1;
      else if (cpu_wr) txe <= 1'b0;
      else if (move_tx) txe <= 1'b1;

      if (ev_start)                    sh_idle <= 1'b1;
      else if (ev_stop)                sh_idle <= 1'b0;
      else if (move_tx)                sh_idle <= 1'b0;
      else if (ev_tx_done && tx_mode)  sh_idle <= 1'b1;

      if (move_tx)         shift_data <= tbuf;
      else if (ev_rx_done) shift_data <= rx_byte;

      if (rd_take) begin
        if (sh_full) begin
          rx_data <= shift_data;
          sh_full <= ev_rx_done;
        end else if (ev_rx_done) begin
          rx_data <= rx_byte;
        end else begin
          rxf <= 1'b0;
        end
      end else if (ev_rx_done) begin
        if (!rxf) begin
          rx_data <= rx_byte;
          rxf     <= 1'b1;
        end else begin
          sh_full <= 1'b1;
        end
      end

      if (ev_tx_done && ack_chk_en) ack_stat <= ack_bit;

      if (ev_arb_lost) begin
        master  <= 1'b0;
        tx_mode <= 1'b0;
      end else if (mode_wr) begin
        master  <= mode_master;
        tx_mode <= mode_tx;
      end

      if (ev_arb_lost) al <= 1'b1;
      else if (clr_al) al <= 1'b0;

      if (ev_start)     busy <= 1'b1;
      else if (ev_stop) busy <= 1'b0;

      if (ev_stop)       stop_flag <= 1'b1;
      else if (clr_stop) stop_flag <= 1'b0;
    end
  end

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start && !ev_stop |=> busy && txe);

  a_r4_load_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done && tx_mode && !txe && !cpu_wr && !ev_start |=> shift_load && txe);

  a_r5_stall_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done && tx_mode && txe && busy && !cpu_wr && !ev_start && !ev_stop && !ev_arb_lost
    |=> hold && !shift_load);

  a_r6_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_done && !rxf && !cpu_rd |=> rxf && rx_data == $past(rx_byte));

  a_r8_arb_lost: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |=> al && !master && !tx_mode);

  a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop && !ev_start |=> !busy && stop_flag);

endmodule

// File: tb/test_i2c_dbuf_flags.sv
module test_i2c_dbuf_flags;
  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] OP_WR = 3'd0, OP_TXD = 3'd1, OP_RXD = 3'd2,
                         OP_RD = 3'd3, OP_IDLE = 3'd4, OP_MODE = 3'd5;

  // {op, data, txe, rxf, hold, load, shift_data, rx_data}
  localparam int NV = 15;
  localparam logic [30:0] VEC [NV] = '{
    {OP_WR,   8'hA5, 4'b0000, 8'h00, 8'h00},
    {OP_IDLE, 8'h00, 4'b1001, 8'hA5, 8'h00},
    {OP_WR,   8'h3C, 4'b0000, 8'hA5, 8'h00},
    {OP_IDLE, 8'h00, 4'b0000, 8'hA5, 8'h00},
    {OP_TXD,  8'h00, 4'b1001, 8'h3C, 8'h00},
    {OP_TXD,  8'h00, 4'b1010, 8'h3C, 8'h00},
    {OP_IDLE, 8'h00, 4'b1010, 8'h3C, 8'h00},
    {OP_WR,   8'h81, 4'b0000, 8'h3C, 8'h00},
    {OP_IDLE, 8'h00, 4'b1001, 8'h81, 8'h00},
    {OP_MODE, 8'h00, 4'b1000, 8'h81, 8'h00},
    {OP_RXD,  8'h5A, 4'b1100, 8'h5A, 8'h5A},
    {OP_RXD,  8'h77, 4'b1110, 8'h77, 8'h5A},
    {OP_RD,   8'h00, 4'b1100, 8'h77, 8'h77},
    {OP_RD,   8'h00, 4'b1000, 8'h77, 8'h77},
    {OP_RXD,  8'hC3, 4'b1100, 8'hC3, 8'hC3}
  };

  logic clk = 0, rst_n = 0;
  logic cpu_wr = 0, cpu_rd = 0, mode_wr = 0, mode_master = 0, mode_tx = 0;
  logic clr_al = 0, clr_stop = 0, ack_chk_en = 0;
  logic [7:0] cpu_wdata = 0, rx_byte = 0;
  logic [3:0] irq_en = 0;
  logic ev_start = 0, ev_stop = 0, ev_tx_done = 0, ev_rx_done = 0, ev_arb_lost = 0, ack_bit = 0;
  logic master, tx_mode, busy, txe, rxf, al, stop_flag, ack_stat, shift_load, hold, irq;
  logic [7:0] shift_data, rx_data;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_dbuf_flags i_i2c_dbuf_flags (.*);

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    cpu_wr = 0; cpu_rd = 0; mode_wr = 0; clr_al = 0; clr_stop = 0;
    ev_start = 0; ev_stop = 0; ev_tx_done = 0; ev_rx_done = 0; ev_arb_lost = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 flags", {master, tx_mode, busy, txe, rxf, al, stop_flag, ack_stat}, 8'h00);
    chk("R1 misc", {5'd0, hold, shift_load, irq}, 8'h00);
    chk("R1 sd", shift_data, 8'h00);
    chk("R1 rd", rx_data, 8'h00);
    rst_n = 1;
    @(negedge clk);
    mode_wr = 1; mode_master = 1; mode_tx = 1; step();
    chk("R12 mode", {master, tx_mode}, 8'h03);
    ev_start = 1; step();
    chk("R2 start", {busy, txe, hold}, 8'h07);

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      case (v[30:28])
        OP_WR:   begin cpu_wr = 1; cpu_wdata = v[27:20]; end
        OP_TXD:  ev_tx_done = 1;
        OP_RXD:  begin ev_rx_done = 1; rx_byte = v[27:20]; end
        OP_RD:   cpu_rd = 1;
        OP_MODE: begin mode_wr = 1; mode_master = 1; mode_tx = v[20]; end
        default: ;
      endcase
      step();
      chk($sformatf("R3 R4 R5 R6 R7 vec%0d flags", i), {4'd0, txe, rxf, hold, shift_load}, {4'd0, v[19:16]});
      chk($sformatf("R3 R4 R5 vec%0d shift_data", i), shift_data, v[15:8]);
      chk($sformatf("R6 R7 vec%0d rx_data", i), rx_data, v[7:0]);
    end

    mode_wr = 1; mode_master = 1; mode_tx = 1; step();
    ev_tx_done = 1; ack_chk_en = 1; ack_bit = 1; step();
    chk("R10 ack set", ack_stat, 1);
    chk("R5 hold on empty", hold, 1);
    ev_tx_done = 1; ack_chk_en = 0; ack_bit = 0; step();
    chk("R10 ack disabled keeps", ack_stat, 1);
    ev_tx_done = 1; ack_chk_en = 1; ack_bit = 0; step();
    chk("R10 ack cleared", ack_stat, 0);

    ev_arb_lost = 1; step();
    chk("R8 arb", {al, master, tx_mode}, 8'h04);
    mode_wr = 1; mode_master = 1; mode_tx = 1; ev_arb_lost = 1; step();
    chk("R12 arb wins over mode_wr", {master, tx_mode}, 8'h00);
    step();
    chk("R8 al sticky", al, 1);
    clr_al = 1; step();
    chk("R8 al cleared", al, 0);

    ev_stop = 1; step();
    chk("R9 stop", {busy, stop_flag}, 8'h01);
    step();
    chk("R9 stop sticky", stop_flag, 1);
    clr_stop = 1; step();
    chk("R9 stop cleared", stop_flag, 0);

    irq_en = 4'b0001; #1;
    chk("R11 txe enabled", irq, 1);
    irq_en = 4'b0000; #1;
    chk("R11 none enabled", irq, 0);
    irq_en = 4'b0100; #1;
    chk("R11 al enabled al=0", irq, 0);
    ev_arb_lost = 1; step();
    chk("R11 al enabled al=1", irq, 1);
    irq_en = 4'b1000; #1;
    chk("R11 stop enabled stop=0", irq, 0);
    irq_en = 4'b0010; #1;
    chk("R11 rxf enabled", irq, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule